// File: doc/BRIEF.md
# Incremental Cascaded PI Controller

This block closes two nested control loops for a dual-bridge isolated DC-DC converter. It outputs the phase-shift command that sets the timing between the two bridges. The outer loop works on output voltage. Its result is a current demand. The inner loop compares that demand, offset by a current reference, against measured current. The inner loop's result is the phase-shift command.

Both loops use the incremental (velocity) PI form. Each keeps only its previous error and its previous output. Each new output is the previous output plus a proportional term on the change in error and an integral term on the present error. All values are two's-complement fixed point. Gains are unsigned with `FRAC_W` fractional bits.

A loop advances only when the sample strobe is seen. The enable input holds both loops at zero while an external soft-start sequence drives the bridges. When enable rises, regulation starts from a clean state.

Top module: `cascaded_pi_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `cur_dmd_o`, `phase_o` and `valid_o` are all zero until the first sample.
- R2: If `en_i` and `sample_i` are high at a rising edge, that edge updates the outer loop. The error is e = `v_ref_i` - `v_fb_i`. The new `cur_dmd_o` is sat(prev_out + ((kp_v*(e - prev_e) + ki_v*e) >>> FRAC_W)). The limits are `dmd_min_i`/`dmd_max_i`, and FRAC_W defaults to 10.
- R3: The inner loop updates on the rising edge that follows an outer update. Its error is `cur_dmd_o` (the value just produced) + `i_ref_i` - `i_fb_i`. It uses the same incremental formula with `kp_c_i`/`ki_c_i` and the limits `ph_min_i`/`ph_max_i`, and its result appears on `phase_o`.
- R4: Each loop output is clamped to its configured range. The clamped value is the one stored as the previous output for the next sample.
- R5: While enabled, a cycle without `sample_i` leaves `cur_dmd_o` unchanged. A cycle without a pending inner update leaves `phase_o` unchanged, even when the references and feedback inputs change.
- R6: Whenever `en_i` is low at an edge, that edge clears both stored errors and both outputs to zero and drops `valid_o`. Strobes seen while disabled are ignored.
- R7: `valid_o` is high for exactly the one cycle after each inner update, which is two edges after the strobe. Otherwise it is low.
- R8: The fixed-point rescale is an arithmetic right shift, so it rounds toward minus infinity. With a zero state, an error of -1, kp = 1 and ki = 0, the result is -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Loop enable; low clears all state |
| sample_i | input | 1 | Sample strobe, one cycle per control period |
| v_ref_i | input | DW | Voltage reference, signed |
| v_fb_i | input | DW | Measured voltage, signed |
| i_ref_i | input | DW | Current reference offset, signed |
| i_fb_i | input | DW | Measured current, signed |
| kp_v_i | input | GW | Outer proportional gain, unsigned, FRAC_W fraction bits |
| ki_v_i | input | GW | Outer integral gain, unsigned |
| kp_c_i | input | GW | Inner proportional gain, unsigned |
| ki_c_i | input | GW | Inner integral gain, unsigned |
| dmd_min_i | input | DW | Lower clamp of the current demand |
| dmd_max_i | input | DW | Upper clamp of the current demand |
| ph_min_i | input | DW | Lower clamp of the phase command |
| ph_max_i | input | DW | Upper clamp of the phase command |
| cur_dmd_o | output | DW | Outer loop output (current demand) |
| phase_o | output | DW | Inner loop output (phase-shift command) |
| valid_o | output | 1 | One-cycle pulse after each phase update |

## Verification
The directed part has four purposes:
- A fixed step in voltage error shows the proportional and integral terms separately across repeated samples.
- Large gains with opposite error signs drive each loop hard into both clamps, and the samples that follow show whether the clamped value, not the raw sum, was kept.
- A one-count negative error separates floor rounding from truncation toward zero.
- Pulsing the strobe while disabled, and changing inputs between strobes, separates update-on-strobe from free-running behaviour.

Random references, feedback values and gains then test the whole chain against a bench model. Each sample is checked at both stages, so a fault can be placed in the outer loop, in the inner loop, or in the hand-off of the demand value.

// File: rtl/pi_ctrl_pkg.sv
package pi_ctrl_pkg;
  localparam int PI_DW   = 16;
  localparam int PI_GW   = 16;
  localparam int PI_FRAC = 10;

  // accumulator width for an error of ew bits times a gain of gw bits
  function automatic int acc_width(input int ew, input int gw);
    return ew + gw + 3;
  endfunction
endpackage

// File: rtl/pi_sat.sv
module pi_sat #(
  parameter int AW = 36,
  parameter int DW = 16
) (
  input  logic signed [AW-1:0] val_i,
  input  logic signed [DW-1:0] lo_i,
  input  logic signed [DW-1:0] hi_i,
  output logic signed [DW-1:0] val_o
);
  logic signed [AW-1:0] lo_w, hi_w;

  assign lo_w = AW'(lo_i);
  assign hi_w = AW'(hi_i);

  always_comb begin
    if (val_i > hi_w)      val_o = hi_i;
    else if (val_i < lo_w) val_o = lo_i;
    else                   val_o = val_i[DW-1:0];
  end
endmodule

// File: rtl/pi_incr.sv
module pi_incr
  import pi_ctrl_pkg::*;
#(
  parameter int EW   = 17,
  parameter int DW   = PI_DW,
  parameter int GW   = PI_GW,
  parameter int FRAC = PI_FRAC
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 upd_i,
  input  logic signed [EW-1:0] err_i,
  input  logic        [GW-1:0] kp_i,
  input  logic        [GW-1:0] ki_i,
  input  logic signed [DW-1:0] lo_i,
  input  logic signed [DW-1:0] hi_i,
  output logic signed [DW-1:0] out_o
);
  localparam int DEW = EW + 1;
  localparam int AW  = acc_width(DEW, GW);

  logic signed [EW-1:0]  err_q;
  logic signed [DW-1:0]  out_q;
  logic signed [DEW-1:0] derr;
  logic signed [AW-1:0]  kp_w, ki_w, p_term, i_term, sum, scaled, cand;
  logic signed [DW-1:0]  sat_val;

  assign derr   = DEW'(err_i) - DEW'(err_q);
  assign kp_w   = AW'($signed({1'b0, kp_i}));
  assign ki_w   = AW'($signed({1'b0, ki_i}));
  assign p_term = AW'(derr) * kp_w;
  assign i_term = AW'(err_i) * ki_w;
  assign sum    = p_term + i_term;
  assign scaled = sum >>> FRAC;   // floor rescale
  assign cand   = AW'(out_q) + scaled;

  pi_sat #(.AW(AW), .DW(DW)) u_sat (
    .val_i (cand),
    .lo_i  (lo_i),
    .hi_i  (hi_i),
    .val_o (sat_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= '0;
      out_q <= '0;
    end else if (clr_i) begin
      err_q <= '0;
      out_q <= '0;
    end else if (upd_i) begin
      err_q <= err_i;
      out_q <= sat_val;   // clamped value feeds the next increment
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/cascaded_pi_ctrl.sv
module cascaded_pi_ctrl
  import pi_ctrl_pkg::*;
#(
  parameter int DW     = PI_DW,
  parameter int GW     = PI_GW,
  parameter int FRAC_W = PI_FRAC
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 sample_i,
  input  logic signed [DW-1:0] v_ref_i,
  input  logic signed [DW-1:0] v_fb_i,
  input  logic signed [DW-1:0] i_ref_i,
  input  logic signed [DW-1:0] i_fb_i,
  input  logic        [GW-1:0] kp_v_i,
  input  logic        [GW-1:0] ki_v_i,
  input  logic        [GW-1:0] kp_c_i,
  input  logic        [GW-1:0] ki_c_i,
  input  logic signed [DW-1:0] dmd_min_i,
  input  logic signed [DW-1:0] dmd_max_i,
  input  logic signed [DW-1:0] ph_min_i,
  input  logic signed [DW-1:0] ph_max_i,
  output logic signed [DW-1:0] cur_dmd_o,
  output logic signed [DW-1:0] phase_o,
  output logic                 valid_o
);
  localparam int EW_V = DW + 1;
  localparam int EW_C = DW + 2;

  logic signed [EW_V-1:0] err_v;
  logic signed [EW_C-1:0] err_c;
  logic                   stb_q, vld_q;
  logic                   upd_v, upd_c, clr;

  assign clr   = ~en_i;
  assign upd_v = en_i & sample_i;
  assign upd_c = en_i & stb_q;

  assign err_v = EW_V'(v_ref_i) - EW_V'(v_fb_i);

  pi_incr #(.EW(EW_V), .DW(DW), .GW(GW), .FRAC(FRAC_W)) u_outer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .upd_i  (upd_v),
    .err_i  (err_v),
    .kp_i   (kp_v_i),
    .ki_i   (ki_v_i),
    .lo_i   (dmd_min_i),
    .hi_i   (dmd_max_i),
    .out_o  (cur_dmd_o)
  );

  // inner stage runs one cycle behind on the registered demand
  assign err_c = EW_C'(cur_dmd_o) + EW_C'(i_ref_i) - EW_C'(i_fb_i);

  pi_incr #(.EW(EW_C), .DW(DW), .GW(GW), .FRAC(FRAC_W)) u_inner (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .upd_i  (upd_c),
    .err_i  (err_c),
    .kp_i   (kp_c_i),
    .ki_i   (ki_c_i),
    .lo_i   (ph_min_i),
    .hi_i   (ph_max_i),
    .out_o  (phase_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      stb_q <= upd_v;
      vld_q <= upd_c;
    end
  end

  assign valid_o = vld_q;
endmodule

// File: rtl/cascaded_pi_ctrl_chk.sv
module cascaded_pi_ctrl_chk #(
  parameter int DW = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 en_i,
  input logic                 sample_i,
  input logic signed [DW-1:0] ph_min_i,
  input logic signed [DW-1:0] ph_max_i,
  input logic signed [DW-1:0] cur_dmd_o,
  input logic signed [DW-1:0] phase_o,
  input logic                 valid_o
);
  // R4
  phase_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (ph_min_i <= ph_max_i)) |-> (phase_o >= ph_min_i && phase_o <= ph_max_i));

  // R5
  dmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !sample_i) |=> $stable(cur_dmd_o));

  // R6
  disable_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cur_dmd_o == '0 && phase_o == '0 && !valid_o));

  // R7
  valid_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(sample_i && en_i, 2));

  // R3
  inner_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sample_i && en_i) ##1 en_i) |=> valid_o);
endmodule

bind cascaded_pi_ctrl cascaded_pi_ctrl_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .sample_i  (sample_i),
  .ph_min_i  (ph_min_i),
  .ph_max_i  (ph_max_i),
  .cur_dmd_o (cur_dmd_o),
  .phase_o   (phase_o),
  .valid_o   (valid_o)
);

// File: tb/cascaded_pi_ctrl_tb.sv
module cascaded_pi_ctrl_tb;
  localparam int  DW = 16;
  localparam int  GW = 16;
  localparam int  FRAC = 10;
  localparam time CLK_PERIOD = 10ns;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic sample_i = 1'b0;
  logic signed [DW-1:0] v_ref_i = '0, v_fb_i = '0, i_ref_i = '0, i_fb_i = '0;
  logic [GW-1:0] kp_v_i = '0, ki_v_i = '0, kp_c_i = '0, ki_c_i = '0;
  logic signed [DW-1:0] dmd_min_i = -16'sd8000, dmd_max_i = 16'sd8000;
  logic signed [DW-1:0] ph_min_i = -16'sd2000, ph_max_i = 16'sd6000;
  logic signed [DW-1:0] cur_dmd_o, phase_o;
  logic valid_o;

  int checks = 0;
  int fails = 0;
  longint m_ev = 0, m_dmd = 0, m_ec = 0, m_ph = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cascaded_pi_ctrl #(.DW(DW), .GW(GW), .FRAC_W(FRAC)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .sample_i(sample_i),
    .v_ref_i(v_ref_i), .v_fb_i(v_fb_i), .i_ref_i(i_ref_i), .i_fb_i(i_fb_i),
    .kp_v_i(kp_v_i), .ki_v_i(ki_v_i), .kp_c_i(kp_c_i), .ki_c_i(ki_c_i),
    .dmd_min_i(dmd_min_i), .dmd_max_i(dmd_max_i),
    .ph_min_i(ph_min_i), .ph_max_i(ph_max_i),
    .cur_dmd_o(cur_dmd_o), .phase_o(phase_o), .valid_o(valid_o)
  );

  function automatic longint pi_step(longint err, longint perr, longint pout,
                                     longint kp, longint ki, longint lo, longint hi);
    longint s, c;
    s = (kp * (err - perr) + ki * err) >>> FRAC;
    c = pout + s;
    if (c > hi) c = hi;
    else if (c < lo) c = lo;
    return c;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_ev = 0; m_dmd = 0; m_ec = 0; m_ph = 0;
  endtask

  task automatic do_sample(input int vr, input int vf, input int ir, input int ifb);
    longint ev, ec;
    @(negedge clk_i);
    v_ref_i = DW'(vr); v_fb_i = DW'(vf); i_ref_i = DW'(ir); i_fb_i = DW'(ifb);
    sample_i = 1'b1;
    ev = longint'(v_ref_i) - longint'(v_fb_i);
    m_dmd = pi_step(ev, m_ev, m_dmd, kp_v_i, ki_v_i, dmd_min_i, dmd_max_i);
    m_ev = ev;
    @(negedge clk_i);
    sample_i = 1'b0;
    chk("R2 outer demand", cur_dmd_o, m_dmd);
    chk("R7 valid low before inner update", valid_o, 0);
    ec = m_dmd + longint'(i_ref_i) - longint'(i_fb_i);
    m_ph = pi_step(ec, m_ec, m_ph, kp_c_i, ki_c_i, ph_min_i, ph_max_i);
    m_ec = ec;
    @(negedge clk_i);
    chk("R3 inner phase", phase_o, m_ph);
    chk("R7 valid pulse", valid_o, 1);
    @(negedge clk_i);
    chk("R7 valid single cycle", valid_o, 0);
    chk("R5 phase held", phase_o, m_ph);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL R7 watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    chk("R1 reset demand", cur_dmd_o, 0);
    chk("R1 reset phase", phase_o, 0);
    chk("R1 reset valid", valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 post-reset phase", phase_o, 0);
    en_i = 1'b1;

    // R8: floor rounding on a -1 error
    kp_v_i = 16'd1; ki_v_i = 16'd0; kp_c_i = 16'd0; ki_c_i = 16'd0;
    do_sample(0, 1, 0, 0);
    chk("R8 floor of -1/1024", cur_dmd_o, -1);

    // R6: disable clears, strobes ignored
    @(negedge clk_i); en_i = 1'b0; sample_i = 1'b1; v_ref_i = 16'sd3000;
    @(negedge clk_i); sample_i = 1'b0;
    @(negedge clk_i);
    chk("R6 demand cleared", cur_dmd_o, 0);
    chk("R6 phase cleared", phase_o, 0);
    chk("R6 valid low", valid_o, 0);
    model_clear();
    en_i = 1'b1;

    // R2 R3: directed step
    kp_v_i = 16'd512; ki_v_i = 16'd256; kp_c_i = 16'd1024; ki_c_i = 16'd128;
    do_sample(1000, 200, 0, 0);
    chk("R2 step demand 600", cur_dmd_o, 600);
    for (int k = 0; k < 4; k++) do_sample(1000, 400 + 100 * k, 50, 300);

    // R5: inputs move, no strobe
    @(negedge clk_i); v_ref_i = 16'sd7000; i_fb_i = -16'sd900;
    repeat (4) @(negedge clk_i);
    chk("R5 demand held", cur_dmd_o, m_dmd);
    chk("R5 phase held idle", phase_o, m_ph);

    // R4: drive both clamps, check stored value is the clamp
    kp_v_i = 16'd40000; ki_v_i = 16'd20000; kp_c_i = 16'd30000; ki_c_i = 16'd9000;
    do_sample(12000, -12000, 0, 0);
    chk("R4 demand at upper clamp", cur_dmd_o, 8000);
    chk("R4 phase at upper clamp", phase_o, 6000);
    do_sample(12000, 11990, 0, 0);
    do_sample(-12000, 12000, 0, 4000);
    chk("R4 demand at lower clamp", cur_dmd_o, -8000);
    chk("R4 phase at lower clamp", phase_o, -2000);
    do_sample(0, 0, 0, 0);

    // re-enable handover from clean state
    @(negedge clk_i); en_i = 1'b0;
    @(negedge clk_i); en_i = 1'b1; model_clear();
    chk("R6 restart demand zero", cur_dmd_o, 0);

    // random mix
    for (int n = 0; n < 300; n++) begin
      kp_v_i = GW'($urandom_range(0, 4095));
      ki_v_i = GW'($urandom_range(0, 2047));
      kp_c_i = GW'($urandom_range(0, 4095));
      ki_c_i = GW'($urandom_range(0, 2047));
      do_sample(int'($urandom_range(0, 8191)) - 4096, int'($urandom_range(0, 8191)) - 4096,
                int'($urandom_range(0, 2047)) - 1024, int'($urandom_range(0, 4095)) - 2048);
      if (n % 50 == 49) begin
        @(negedge clk_i); en_i = 1'b0;
        @(negedge clk_i); en_i = 1'b1; model_clear();
        chk("R6 random clear", phase_o, 0);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule